// File: doc/BRIEF.md
# Keyboard Controller Host Register Interface

This block is the host-facing side of a legacy PC keyboard controller. The host sees two byte-wide I/O ports on a small parallel bus with an active-low chip select, active-low read and write strobes and one address bit. Address high selects the command/status side (the port the host knows as 0x64). Address low selects the data side (port 0x60). A write to either port fills a one-byte input buffer. A read of the data side returns the one-byte output buffer. A read of the command side returns an eight-bit status byte.

Controller logic inside the chip uses a second set of signals. With these it loads output bytes tagged as keyboard or mouse traffic, consumes host-written bytes and raises the time-out and parity error flags. A built-in sequencer answers the self-test command: it consumes the command byte, waits a fixed number of cycles, then posts the pass code, raises the system flag and enables the keyboard side. Both devices stay disabled from reset until that happens.

All bus inputs are taken to be synchronous to `clk`. An access counts once, in the first cycle its strobe is seen active together with chip select.

Top module: `kbc_host_if`

## Requirements
- R1: A host read with `addr`=1 returns the status byte. A read with `addr`=0 returns the output-buffer byte, even when status bit 0 is clear. The status byte is {bit7 parity error, bit6 time-out, bit5 mouse source, bit4 inhibit level, bit3 command port, bit2 system flag, bit1 input full, bit0 output full}.
- R2: Status bit 0 sets on the clock edge that accepts a load into the output buffer. It clears on the edge of a host read of the data port. A status-port read changes nothing.
- R3: While status bit 0 is 1, `ld_busy` is 1 and a controller load is refused: the buffered byte and its tags keep their values. A load in the same cycle as a data-port read is also refused.
- R4: Status bit 1 sets on a host write to either port and clears when `ib_pop` is pulsed. A write in the same cycle as a pop wins: the bit stays 1 and the new byte is held.
- R5: Status bit 3 becomes 1 after a write to the command port and 0 after a write to the data port. It is held across pops. `ib_cmd` gives the same tag for the byte on `ib_data`.
- R6: Status bit 4 takes the level of `inhibit_n` on the edge that accepts a load and keeps it until the next accepted load.
- R7: Status bit 5 takes `ld_mouse` on an accepted load (0 keyboard, 1 mouse). Self-test results are tagged keyboard.
- R8: A pulse on `set_timeout` or `set_parity` sets status bit 6 or bit 7. The bit holds until the next accepted output load clears it. A set in the same cycle as a load leaves the bit at 1.
- R9: After reset the status byte is 0x00 and `kbd_en` and `aux_en` are 0. `aux_en` stays 0 after self-test.
- R10: Byte 0xAA written to the command port starts self-test. The sequencer consumes it and, ST_DELAY cycles later, loads 0x55 into the output buffer, sets status bit 2 and sets `kbd_en`. It waits while the output buffer is full. 0xAA written to the data port, or another command byte, starts nothing.
- R11: A strobe with `cs_n` high has no effect. A strobe held low for several cycles counts as one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Host chip select, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| addr | input | 1 | 1 = command/status port, 0 = data port |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data |
| inhibit_n | input | 1 | Inhibit input level, captured into status bit 4 on load |
| ld_valid | input | 1 | Controller request to load the output buffer |
| ld_data | input | 8 | Byte to load |
| ld_mouse | input | 1 | Source tag of the loaded byte, 1 = mouse |
| ld_busy | output | 1 | Load cannot be taken this cycle |
| ib_pop | input | 1 | Controller consumes the input byte |
| ib_data | output | 8 | Byte held in the input buffer |
| ib_cmd | output | 1 | The held byte came through the command port |
| ib_full | output | 1 | Input buffer holds a byte |
| set_timeout | input | 1 | Raise the time-out flag |
| set_parity | input | 1 | Raise the parity error flag |
| kbd_en | output | 1 | Keyboard side enabled |
| aux_en | output | 1 | Mouse side enabled |

## Verification
Two operations can fall on the same edge. A host data-port read can clear the output buffer while the controller tries to load it. A host write can refill the input buffer while the controller pops it. The bench drives each pair in one cycle on purpose. It then checks that the load was refused with `ld_busy` high and the old byte was read out, and that the input buffer stays full with the newer byte. Random sequences of writes, pops, loads, reads and error pulses are compared against a bench model of the status byte after every step.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam logic [7:0] SELFTEST_CMD  = 8'hAA;
  localparam logic [7:0] SELFTEST_PASS = 8'h55;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_POST = 2'd2
  } st_state_e;
endpackage

// File: rtl/kbc_bus_strobe.sv
module kbc_bus_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic rd_pulse,
  output logic wr_pulse
);
  logic rd_act, wr_act, rd_q, wr_q;

  assign rd_act = ~cs_n & ~rd_n;
  assign wr_act = ~cs_n & ~wr_n;
  assign rd_pulse = rd_act & ~rd_q;
  assign wr_pulse = wr_act & ~wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      rd_q <= rd_act;
      wr_q <= wr_act;
    end
  end
endmodule

// File: rtl/kbc_in_buf.sv
module kbc_in_buf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_cmd,
  input  logic [DW-1:0] wr_byte,
  input  logic          pop,
  output logic          full,
  output logic          cmd,
  output logic [DW-1:0] byte_q
);
  logic          full_d, cmd_d;
  logic [DW-1:0] byte_d;

  always_comb begin
    full_d = full;
    cmd_d  = cmd;
    byte_d = byte_q;
    if (wr_en) begin
      full_d = 1'b1;
      cmd_d  = wr_cmd;
      byte_d = wr_byte;
    end else if (pop) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full   <= 1'b0;
      cmd    <= 1'b0;
      byte_q <= '0;
    end else begin
      full   <= full_d;
      cmd    <= cmd_d;
      byte_q <= byte_d;
    end
  end
endmodule

// File: rtl/kbc_out_buf.sv
module kbc_out_buf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_byte,
  input  logic          load_mouse,
  input  logic          inh_level,
  input  logic          host_take,
  input  logic          set_to,
  input  logic          set_pe,
  output logic          full,
  output logic          mouse,
  output logic          inh,
  output logic          to_err,
  output logic          pe_err,
  output logic [DW-1:0] byte_q
);
  logic          full_d, mouse_d, inh_d, to_d, pe_d;
  logic [DW-1:0] byte_d;

  always_comb begin
    full_d  = full;
    mouse_d = mouse;
    inh_d   = inh;
    to_d    = to_err;
    pe_d    = pe_err;
    byte_d  = byte_q;
    if (load) begin
      full_d  = 1'b1;
      mouse_d = load_mouse;
      inh_d   = inh_level;
      byte_d  = load_byte;
      to_d    = 1'b0;
      pe_d    = 1'b0;
    end else if (host_take) begin
      full_d = 1'b0;
    end
    if (set_to) to_d = 1'b1;
    if (set_pe) pe_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full   <= 1'b0;
      mouse  <= 1'b0;
      inh    <= 1'b0;
      to_err <= 1'b0;
      pe_err <= 1'b0;
      byte_q <= '0;
    end else begin
      full   <= full_d;
      mouse  <= mouse_d;
      inh    <= inh_d;
      to_err <= to_d;
      pe_err <= pe_d;
      byte_q <= byte_d;
    end
  end
endmodule

// File: rtl/kbc_selftest.sv
module kbc_selftest
  import kbc_pkg::*;
#(
  parameter int DW       = 8,
  parameter int ST_DELAY = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ib_full,
  input  logic          ib_cmd,
  input  logic [DW-1:0] ib_byte,
  input  logic          ob_full,
  output logic          st_pop,
  output logic          st_load,
  output logic          sys_flag,
  output logic          kbd_en
);
  localparam int CW = (ST_DELAY > 1) ? $clog2(ST_DELAY) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(ST_DELAY - 1);

  st_state_e     state, state_d;
  logic [CW-1:0] cnt, cnt_d;
  logic          sys_d, kbd_d;

  always_comb begin
    state_d = state;
    cnt_d   = cnt;
    sys_d   = sys_flag;
    kbd_d   = kbd_en;
    st_pop  = 1'b0;
    st_load = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (ib_full && ib_cmd && ib_byte == SELFTEST_CMD) begin
          st_pop  = 1'b1;
          cnt_d   = '0;
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        cnt_d = cnt + 1'b1;
        if (cnt == CNT_LAST) state_d = ST_POST;
      end
      ST_POST: begin
        if (!ob_full) begin
          st_load = 1'b1;
          sys_d   = 1'b1;
          kbd_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      sys_flag <= 1'b0;
      kbd_en   <= 1'b0;
    end else begin
      state    <= state_d;
      cnt      <= cnt_d;
      sys_flag <= sys_d;
      kbd_en   <= kbd_d;
    end
  end
endmodule

// File: rtl/kbc_host_if.sv
module kbc_host_if
  import kbc_pkg::*;
#(
  parameter int ST_DELAY = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       inhibit_n,
  input  logic       ld_valid,
  input  logic [7:0] ld_data,
  input  logic       ld_mouse,
  output logic       ld_busy,
  input  logic       ib_pop,
  output logic [7:0] ib_data,
  output logic       ib_cmd,
  output logic       ib_full,
  input  logic       set_timeout,
  input  logic       set_parity,
  output logic       kbd_en,
  output logic       aux_en
);
  localparam int DW = 8;

  logic          rd_pulse, wr_pulse, host_take;
  logic          st_pop, st_load, sys_flag;
  logic          ob_full, ob_mouse, ob_inh, ob_to, ob_pe;
  logic [DW-1:0] ob_byte, load_byte;
  logic          load_en, load_mouse;
  logic [DW-1:0] status;

  kbc_bus_strobe u_bus (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .rd_pulse(rd_pulse), .wr_pulse(wr_pulse)
  );

  kbc_in_buf #(.DW(DW)) u_ib (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_pulse), .wr_cmd(addr),
    .wr_byte(wdata), .pop(ib_pop | st_pop), .full(ib_full),
    .cmd(ib_cmd), .byte_q(ib_data)
  );

  kbc_selftest #(.DW(DW), .ST_DELAY(ST_DELAY)) u_st (
    .clk(clk), .rst_n(rst_n), .ib_full(ib_full), .ib_cmd(ib_cmd),
    .ib_byte(ib_data), .ob_full(ob_full), .st_pop(st_pop),
    .st_load(st_load), .sys_flag(sys_flag), .kbd_en(kbd_en)
  );

  assign host_take  = rd_pulse & ~addr;
  assign ld_busy    = ob_full | st_load;
  assign load_en    = st_load | (ld_valid & ~ob_full);
  assign load_byte  = st_load ? SELFTEST_PASS : ld_data;
  assign load_mouse = st_load ? 1'b0 : ld_mouse;

  kbc_out_buf #(.DW(DW)) u_ob (
    .clk(clk), .rst_n(rst_n), .load(load_en), .load_byte(load_byte),
    .load_mouse(load_mouse), .inh_level(inhibit_n), .host_take(host_take),
    .set_to(set_timeout), .set_pe(set_parity), .full(ob_full),
    .mouse(ob_mouse), .inh(ob_inh), .to_err(ob_to), .pe_err(ob_pe),
    .byte_q(ob_byte)
  );

  assign status = {ob_pe, ob_to, ob_mouse, ob_inh, ib_cmd, sys_flag, ib_full, ob_full};
  assign rdata  = addr ? status : ob_byte;
  assign aux_en = 1'b0;
endmodule

// File: rtl/kbc_host_if_chk.sv
module kbc_host_if_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ld_valid,
  input logic       ld_busy,
  input logic       wr_pulse,
  input logic       addr,
  input logic       kbd_en,
  input logic [7:0] status,
  input logic [7:0] ob_byte
);
  AST_LOAD_SETS_OBF: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && !ld_busy |=> status[0]); // R2
  AST_FULL_KEEPS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] |=> ob_byte == $past(ob_byte)); // R3
  AST_WRITE_SETS_IBF: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> status[1]); // R4
  AST_PORT_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> status[3] == $past(addr)); // R5
  AST_SYSFLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    status[2] |=> status[2]); // R10
  AST_KBD_AFTER_TEST: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_en |-> status[2]); // R10
endmodule

bind kbc_host_if kbc_host_if_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_busy(ld_busy),
  .wr_pulse(wr_pulse), .addr(addr), .kbd_en(kbd_en),
  .status(status), .ob_byte(ob_byte)
);

// File: tb/tb_kbc_host_if.sv
module tb_kbc_host_if;
  localparam int ST_DELAY = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic inhibit_n = 1'b1;
  logic ld_valid = 1'b0, ld_mouse = 1'b0, ib_pop = 1'b0;
  logic [7:0] ld_data = '0;
  logic ld_busy, ib_cmd, ib_full, kbd_en, aux_en;
  logic [7:0] ib_data;
  logic set_timeout = 1'b0, set_parity = 1'b0;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // bench model of the visible state
  bit m_obf, m_ibf, m_cmd, m_sys, m_inh, m_src, m_to, m_pe;
  logic [7:0] m_ob, m_ib;

  always #2 clk = ~clk;

  kbc_host_if #(.ST_DELAY(ST_DELAY)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .inhibit_n(inhibit_n),
    .ld_valid(ld_valid), .ld_data(ld_data), .ld_mouse(ld_mouse),
    .ld_busy(ld_busy), .ib_pop(ib_pop), .ib_data(ib_data), .ib_cmd(ib_cmd),
    .ib_full(ib_full), .set_timeout(set_timeout), .set_parity(set_parity),
    .kbd_en(kbd_en), .aux_en(aux_en)
  );

  function automatic logic [7:0] exp_status();
    return {m_pe, m_to, m_src, m_inh, m_cmd, m_sys, m_ibf, m_obf};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    m_ibf = 1'b1; m_ib = d; m_cmd = a;
  endtask

  task automatic host_read(input logic a, output logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
    if (!a) m_obf = 1'b0;
  endtask

  task automatic check_status(input string req);
    logic [7:0] s;
    host_read(1'b1, s);
    check(req, s, exp_status());
  endtask

  task automatic ctl_load(input logic [7:0] d, input logic mouse, input logic inh);
    @(negedge clk);
    ld_valid = 1'b1; ld_data = d; ld_mouse = mouse; inhibit_n = inh;
    #1 check("R3 busy", {7'd0, ld_busy}, {7'd0, m_obf});
    @(negedge clk);
    ld_valid = 1'b0;
    if (!m_obf) begin
      m_obf = 1'b1; m_ob = d; m_src = mouse; m_inh = inh; m_to = 1'b0; m_pe = 1'b0;
    end
  endtask

  task automatic ctl_pop(input string req);
    @(negedge clk);
    if (m_ibf) begin
      check({req, " ib_data"}, ib_data, m_ib);
      check({req, " ib_cmd"}, {7'd0, ib_cmd}, {7'd0, m_cmd});
    end
    ib_pop = 1'b1;
    @(negedge clk);
    ib_pop = 1'b0;
    m_ibf = 1'b0;
  endtask

  task automatic err_pulse(input logic to, input logic pe);
    @(negedge clk);
    set_timeout = to; set_parity = pe;
    @(negedge clk);
    set_timeout = 1'b0; set_parity = 1'b0;
    if (to) m_to = 1'b1;
    if (pe) m_pe = 1'b1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    m_obf = 0; m_ibf = 0; m_cmd = 0; m_sys = 0; m_inh = 0; m_src = 0; m_to = 0; m_pe = 0;
    m_ob = '0; m_ib = '0;
    void'($urandom(32'd2718));
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R9 reset state
    check_status("R9 reset status");
    check("R9 kbd_en", {7'd0, kbd_en}, 8'd0);
    check("R9 aux_en", {7'd0, aux_en}, 8'd0);

    // R1 data port read while empty returns buffered byte (reset value)
    host_read(1'b0, v);
    check("R1 empty data read", v, 8'h00);

    // R11 strobes without chip select
    @(negedge clk); wr_n = 1'b0; rd_n = 1'b0; addr = 1'b0; wdata = 8'h77;
    idle(2); wr_n = 1'b1; rd_n = 1'b1;
    check_status("R11 no cs");

    // R11 held strobe counts once
    @(negedge clk); cs_n = 1'b0; wr_n = 1'b0; addr = 1'b0; wdata = 8'h3C;
    idle(4); cs_n = 1'b1; wr_n = 1'b1;
    m_ibf = 1; m_ib = 8'h3C; m_cmd = 0;
    ctl_pop("R11 held write");
    idle(2);
    check_status("R11 single access");

    // R10 0xAA to data port is not self-test
    host_write(1'b0, 8'hAA);
    idle(ST_DELAY + 8);
    check_status("R10 AA on data port");
    ctl_pop("R10 data AA");
    // R10 other command is not self-test
    host_write(1'b1, 8'h12);
    idle(ST_DELAY + 8);
    check_status("R10 other command");
    ctl_pop("R10 cmd 12");
    check("R9 kbd before test", {7'd0, kbd_en}, 8'd0);

    // R10 self-test with output buffer occupied: must wait
    ctl_load(8'h9E, 1'b1, 1'b0);
    inhibit_n = 1'b1;
    host_write(1'b1, 8'hAA);
    m_ibf = 1'b0;
    idle(ST_DELAY + 10);
    check_status("R10 waits on full buffer");
    host_read(1'b0, v);
    check("R1 data read", v, 8'h9E);
    idle(4);
    m_obf = 1; m_ob = 8'h55; m_src = 0; m_inh = 1; m_to = 0; m_pe = 0; m_sys = 1;
    check_status("R10 self-test status");
    check("R10 kbd_en", {7'd0, kbd_en}, 8'd1);
    check("R9 aux_en after test", {7'd0, aux_en}, 8'd0);
    host_read(1'b0, v);
    check("R10 pass code", v, 8'h55);
    check_status("R2 obf cleared");

    // R2 status read has no side effect
    ctl_load(8'h5A, 1'b0, 1'b0);
    check_status("R2 status read 1");
    check_status("R2 status read 2");
    // R3 refused load
    ctl_load(8'hC3, 1'b1, 1'b1);
    check_status("R3 tags kept");
    host_read(1'b0, v);
    check("R3 byte kept", v, 8'h5A);

    // R3 load in same cycle as data read is refused
    ctl_load(8'h11, 1'b0, 1'b1);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; addr = 1'b0;
    ld_valid = 1'b1; ld_data = 8'h22; ld_mouse = 1'b1;
    #1 check("R3 busy during read", {7'd0, ld_busy}, 8'd1);
    v = rdata;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1; ld_valid = 1'b0;
    check("R3 concurrent read data", v, 8'h11);
    m_obf = 1'b0;
    check_status("R3 concurrent load refused");

    // R4 write in same cycle as pop
    host_write(1'b0, 8'h40);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; addr = 1'b1; wdata = 8'h41; ib_pop = 1'b1;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1; ib_pop = 1'b0;
    m_ibf = 1; m_ib = 8'h41; m_cmd = 1;
    check_status("R4 write wins over pop");
    ctl_pop("R4 newer byte");
    check_status("R5 tag held after pop");

    // R8 error set in same cycle as load
    @(negedge clk);
    ld_valid = 1'b1; ld_data = 8'hE1; ld_mouse = 1'b0; inhibit_n = 1'b0; set_timeout = 1'b1;
    @(negedge clk);
    ld_valid = 1'b0; set_timeout = 1'b0;
    m_obf = 1; m_ob = 8'hE1; m_src = 0; m_inh = 0; m_to = 1; m_pe = 0;
    check_status("R8 set wins over load clear");
    host_read(1'b0, v);
    check("R8 byte", v, 8'hE1);

    // random phase against the model
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom_range(0, 5));
      case (op)
        0: begin
          logic a; logic [7:0] d;
          a = 1'($urandom_range(0, 1)); d = 8'($urandom);
          if (a && d == 8'hAA) d = 8'hAB;
          host_write(a, d);
        end
        1: ctl_pop("R4 random pop");
        2: ctl_load(8'($urandom), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        3: begin
          logic [7:0] e;
          e = m_ob;
          host_read(1'b0, v);
          check("R1 random data read", v, e);
        end
        4: err_pulse(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        default: idle(1);
      endcase
      check_status("R6 R7 R8 random status");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule